// File: doc/BRIEF.md
# Ping-Pong Complex Frame Buffer

This block sits between a pair of synchronized 12-bit converter channels and a transform engine. Each sample enable carries one complex value: the real part comes from one channel and the imaginary part from the other, and both are taken in the same cycle. Samples are gathered into frames of 256. A frame is stored in one half of a 512-word by 36-bit single-ported memory. The other half holds the previous complete frame, and the transform engine reads it back one word per request.

The memory clock runs at three times the sample rate, so the single port is shared in time. The first cycle after each sample enable writes the pending sample. The next two cycles serve reader requests, which gives the reader up to two words per sample period. No sample is ever dropped.

When a frame finishes, the block pulses a ready signal with the number of the bank it just filled and starts filling the other bank. The reader signals with a done pulse that it has finished a frame. If another frame completes before that pulse, a sticky overrun flag is raised, and capture still goes on.

Top module: `cplx_frame_pingpong`

## Requirements
- R1: After reset, `frm_rdy`, `rd_vld`, `rd_ack` and `overrun` are all 0.
- R2: A sample is stored and returned as one 36-bit word. The real part is in bits 11:0, the imaginary part in bits 23:12, and bits 35:24 are zero.
- R3: `frm_rdy` is high for exactly one cycle, two cycles after the sample enable of the 256th sample of a frame. `frm_bank` gives the bank just filled. The first frame after reset goes to bank 0, and later frames alternate between banks.
- R4: The cycle right after a `smp_en` cycle is a write slot, and `rd_ack` is 0 in it. The two cycles after it are read slots, and in each of them a pending `rd_req` is acknowledged in the same cycle.
- R5: `rd_vld` is high exactly one cycle after each `rd_ack`, and only then. `rd_word` then holds the word stored at `rd_addr` in the readable bank.
- R6: Reads address the bank that was most recently reported by `frm_rdy`. `rd_addr` (8 bits) selects the word within that bank.
- R7: `overrun` is set when a frame completes while the previous completed frame has not yet been released by a `rd_done` pulse. It then holds until reset. Capture and `frm_rdy` reporting continue while it is set.
- R8: With one sample enable every three cycles and a reader that keeps requesting, every sample of every frame is read back in order with its exact value.
- R9: A `rd_req` held through a write slot is not acknowledged there, and it is served in the next read slot without being lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock, three times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | One-cycle pulse when a new sample is present |
| smp_re | input | 12 | Real part of the sample |
| smp_im | input | 12 | Imaginary part of the sample |
| frm_rdy | output | 1 | One-cycle pulse when a frame is complete |
| frm_bank | output | 1 | Bank completed by the last frame |
| rd_done | input | 1 | Pulse from the reader releasing the current frame |
| rd_req | input | 1 | Reader request; held until acknowledged |
| rd_addr | input | 8 | Word index within the readable bank |
| rd_ack | output | 1 | Request accepted this cycle |
| rd_vld | output | 1 | `rd_word` valid |
| rd_word | output | 36 | Returned memory word |
| overrun | output | 1 | Sticky: a frame completed before the previous one was released |

## Verification
A sample write and a reader request compete for the single port whenever the reader asks in the cycle right after a sample enable. The bench drives a sample every three cycles and holds its request level across all slots at once. It then checks that acknowledgement is withheld in every write slot and given in both read slots. A scoreboard confirms that each stalled request still returns the right word of the finished bank. A second collision, between frame completion and the reader's release, is provoked by withholding the release over two frames, which must raise the sticky overrun while bank alternation goes on.

// File: rtl/fpb_pkg.sv
// Package: shared constants for the complex ping-pong frame buffer.
// Assumes two converter channels of equal width, packed side by side into one memory word.
package fpb_pkg;
    localparam int SMP_W   = 12;   // bits per real or imaginary part
    localparam int FRM_LEN = 256;  // samples per frame (power of two)
    localparam int WORD_W  = 36;   // memory word width
    localparam int SLOTS   = 3;    // port cycles per sample period
endpackage

// File: rtl/fpb_slot_seq.sv
// Module: fpb_slot_seq
// Generates the repeating port slot pattern. The cycle after a sample enable is
// slot 0 (write slot); the count then walks to SLOTS-1 and wraps.
// Assumes sample enables arrive no closer than SLOTS cycles apart.
module fpb_slot_seq #(
    parameter int SLOTS = fpb_pkg::SLOTS,
    localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    output logic wr_slot
);
    logic [SW-1:0] slot_q;

    // Slot counter, realigned to zero by every sample enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (smp_en)
            slot_q <= '0;
        else if (slot_q == SW'(SLOTS - 1))
            slot_q <= '0;
        else
            slot_q <= slot_q + 1'b1;
    end

    assign wr_slot = (slot_q == '0);
endmodule

// File: rtl/fpb_capture.sv
// Module: fpb_capture
// Holds the pending sample, writes it in the write slot, counts the frame and
// swaps banks. Produces the frame-ready pulse, the readable bank and the overrun flag.
// Assumes at most one sample enable per slot period.
module fpb_capture #(
    parameter int SMP_W   = fpb_pkg::SMP_W,
    parameter int FRM_LEN = fpb_pkg::FRM_LEN,
    parameter int WORD_W  = fpb_pkg::WORD_W,
    localparam int IDX_W  = $clog2(FRM_LEN),
    localparam int ADDR_W = IDX_W + 1,
    localparam int PAD_W  = WORD_W - 2 * SMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic [SMP_W-1:0]  smp_re,
    input  logic [SMP_W-1:0]  smp_im,
    input  logic              wr_slot,
    input  logic              rd_done,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_word,
    output logic              frm_rdy,
    output logic              frm_bank,
    output logic              rd_bank,
    output logic              overrun
);
    logic [WORD_W-1:0] packed_w;
    logic [WORD_W-1:0] pend_word_q;
    logic              pend_vld_q;
    logic [IDX_W-1:0]  idx_q;
    logic              bank_q;
    logic              frm_rdy_q;
    logic              frm_bank_q;
    logic              rd_bank_q;
    logic              busy_q;
    logic              ovr_q;
    logic              frame_done;

    // Word packing: real low, imaginary above it, zero padding on top
    generate
        if (PAD_W > 0) begin : g_pad
            assign packed_w = {{PAD_W{1'b0}}, smp_im, smp_re};
        end else begin : g_nopad
            assign packed_w = {smp_im, smp_re};
        end
    endgenerate

    // Pending sample register: loaded on enable, emptied by its write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld_q  <= 1'b0;
            pend_word_q <= '0;
        end else if (smp_en) begin
            pend_vld_q  <= 1'b1;
            pend_word_q <= packed_w;
        end else if (wr_en) begin
            pend_vld_q  <= 1'b0;
        end
    end

    assign wr_en      = wr_slot & pend_vld_q;
    assign frame_done = wr_en & (idx_q == IDX_W'(FRM_LEN - 1));

    // Write index and bank: step per write, swap bank at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            bank_q <= 1'b0;
        end else if (frame_done) begin
            idx_q  <= '0;
            bank_q <= ~bank_q;
        end else if (wr_en) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Frame hand-over: ready pulse, reported bank and readable bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_rdy_q  <= 1'b0;
            frm_bank_q <= 1'b0;
            rd_bank_q  <= 1'b0;
        end else begin
            frm_rdy_q <= frame_done;
            if (frame_done) begin
                frm_bank_q <= bank_q;
                rd_bank_q  <= bank_q;
            end
        end
    end

    // Reader ownership and sticky overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (frame_done) begin
            busy_q <= 1'b1;
            if (busy_q && !rd_done)
                ovr_q <= 1'b1;
        end else if (rd_done) begin
            busy_q <= 1'b0;
        end
    end

    assign wr_addr  = {bank_q, idx_q};
    assign wr_word  = pend_word_q;
    assign frm_rdy  = frm_rdy_q;
    assign frm_bank = frm_bank_q;
    assign rd_bank  = rd_bank_q;
    assign overrun  = ovr_q;
endmodule

// File: rtl/fpb_read_port.sv
// Module: fpb_read_port
// Accepts reader requests in read slots only and forms the memory read address
// in the readable bank. Data valid follows acceptance by one cycle.
// Assumes the reader holds its request until it sees the acknowledge.
module fpb_read_port #(
    parameter int IDX_W   = $clog2(fpb_pkg::FRM_LEN),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_addr,
    input  logic              rd_bank,
    input  logic              wr_slot,
    output logic              rd_ack,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              rd_vld
);
    logic vld_q;

    assign rd_ack      = rd_req & ~wr_slot;
    assign mem_rd_addr = {rd_bank, rd_addr};

    // Valid flag tracking the one-cycle read latency
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= 1'b0;
        else
            vld_q <= rd_ack;
    end

    assign rd_vld = vld_q;
endmodule

// File: rtl/fpb_spram.sv
// Module: fpb_spram
// Single-ported memory with a registered read. Writes take priority when both
// enables are high. Assumes the caller never asks for both in one cycle.
module fpb_spram #(
    parameter int DEPTH   = 2 * fpb_pkg::FRM_LEN,
    parameter int WIDTH   = fpb_pkg::WORD_W,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Single port access: write or registered read
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        else if (re)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/cplx_frame_pingpong.sv
// Module: cplx_frame_pingpong
// Captures complex samples into frames and stores them in a two-bank memory.
// One single port is time-sliced, so the reader can fetch the previous frame
// while the next one is being written.
// Assumes smp_en pulses no more often than once every SLOTS clock cycles and
// is already synchronous to clk.
module cplx_frame_pingpong #(
    parameter int SMP_W   = fpb_pkg::SMP_W,
    parameter int FRM_LEN = fpb_pkg::FRM_LEN,
    parameter int WORD_W  = fpb_pkg::WORD_W,
    parameter int SLOTS   = fpb_pkg::SLOTS,
    localparam int IDX_W  = $clog2(FRM_LEN),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic [SMP_W-1:0]  smp_re,
    input  logic [SMP_W-1:0]  smp_im,
    output logic              frm_rdy,
    output logic              frm_bank,
    input  logic              rd_done,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic              rd_ack,
    output logic              rd_vld,
    output logic [WORD_W-1:0] rd_word,
    output logic              overrun
);
    logic              wr_slot;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_word;
    logic              rd_bank;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [ADDR_W-1:0] mem_addr;

    fpb_slot_seq #(.SLOTS(SLOTS)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_en  (smp_en),
        .wr_slot (wr_slot)
    );

    fpb_capture #(.SMP_W(SMP_W), .FRM_LEN(FRM_LEN), .WORD_W(WORD_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .smp_re   (smp_re),
        .smp_im   (smp_im),
        .wr_slot  (wr_slot),
        .rd_done  (rd_done),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_word  (wr_word),
        .frm_rdy  (frm_rdy),
        .frm_bank (frm_bank),
        .rd_bank  (rd_bank),
        .overrun  (overrun)
    );

    fpb_read_port #(.IDX_W(IDX_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_bank     (rd_bank),
        .wr_slot     (wr_slot),
        .rd_ack      (rd_ack),
        .mem_rd_addr (mem_rd_addr),
        .rd_vld      (rd_vld)
    );

    // Port address select: write slot owns the port when a write is pending
    assign mem_addr = wr_en ? wr_addr : mem_rd_addr;

    fpb_spram #(.DEPTH(2 * FRM_LEN), .WIDTH(WORD_W)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .re    (rd_ack),
        .addr  (mem_addr),
        .wdata (wr_word),
        .rdata (rd_word)
    );
endmodule

// File: rtl/cplx_frame_pingpong_chk.sv
// Module: cplx_frame_pingpong_chk
// Port-level protocol checker, bound to every cplx_frame_pingpong instance.
// Assumes default parameter widths.
module cplx_frame_pingpong_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        smp_en,
    input logic        frm_rdy,
    input logic        frm_bank,
    input logic        rd_req,
    input logic        rd_ack,
    input logic        rd_vld,
    input logic [35:0] rd_word,
    input logic        overrun
);
    logic en_d;
    logic seen_q;
    logic last_bank_q;

    // Checker history: previous enable and last reported bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d        <= 1'b0;
            seen_q      <= 1'b0;
            last_bank_q <= 1'b0;
        end else begin
            en_d <= smp_en;
            if (frm_rdy) begin
                seen_q      <= 1'b1;
                last_bank_q <= frm_bank;
            end
        end
    end

    // R3
    frm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_rdy |=> !frm_rdy);

    // R3
    bank_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_rdy && seen_q) |-> (frm_bank != last_bank_q));

    // R4
    wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_d |-> !rd_ack);

    // R5
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> rd_vld);

    // R5
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ack |=> !rd_vld);

    // R2
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> (rd_word[35:24] == 12'h000));

    // R7
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R9
    ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> rd_req);
endmodule

bind cplx_frame_pingpong cplx_frame_pingpong_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_en   (smp_en),
    .frm_rdy  (frm_rdy),
    .frm_bank (frm_bank),
    .rd_req   (rd_req),
    .rd_ack   (rd_ack),
    .rd_vld   (rd_vld),
    .rd_word  (rd_word),
    .overrun  (overrun)
);

// File: tb/sim_cplx_frame_pingpong.sv
module sim_cplx_frame_pingpong;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_en = 1'b0;
    logic [11:0] smp_re = '0;
    logic [11:0] smp_im = '0;
    logic        frm_rdy;
    logic        frm_bank;
    logic        rd_done = 1'b0;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic        rd_ack;
    logic        rd_vld;
    logic [35:0] rd_word;
    logic        overrun;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_en_cyc = -10;
    int since_en = 0;
    int frm_cnt = 0;
    logic exp_bank = 1'b0;
    logic wr_bank_m = 1'b0;
    logic reader_on = 1'b0;
    logic reader_busy = 1'b0;
    logic [35:0] model [512];
    logic [35:0] exp_q [$];
    logic        rdy_q [$];

    cplx_frame_pingpong u0 (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Cycle counter and slot tracking, updated at the active edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (smp_en) since_en <= 1;
        else if (since_en != 0) since_en <= since_en + 1;
    end

    // Monitor: frame pulses, slot rules and read scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (frm_rdy) begin
                chk(frm_bank == exp_bank, "R3 bank", frm_bank, exp_bank);
                chk(cyc == last_en_cyc + 2, "R3 timing", cyc, last_en_cyc + 2);
                exp_bank = ~exp_bank;
                frm_cnt++;
                if (reader_on) rdy_q.push_back(frm_bank);
            end
            if (rd_req && since_en == 1)
                chk(rd_ack == 1'b0, "R4 R9 write slot", rd_ack, 0);
            else if (rd_req && (since_en == 2 || since_en == 3))
                chk(rd_ack == 1'b1, "R4 read slot", rd_ack, 1);
            if (rd_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected valid", 1, 0);
                end else begin
                    logic [35:0] e;
                    e = exp_q.pop_front();
                    chk(rd_word == e, "R2 R5 R6 R8 data", rd_word, e);
                end
            end
        end
    end

    function automatic logic [11:0] re_of(input int f, input int i);
        if (i == 0) return 12'h000;
        if (i == 255) return 12'hFFF;
        return 12'((f * 256 + i) * 37 + 5);
    endfunction

    function automatic logic [11:0] im_of(input int f, input int i);
        if (i == 0) return 12'hFFF;
        if (i == 255) return 12'h000;
        return 12'((f * 911 + i * 53) ^ 12'hA5C);
    endfunction

    // Driver: one sample every three cycles, expected word stored in the model
    task automatic send(input int f, input int i);
        @(posedge clk); #1;
        smp_en = 1'b1;
        smp_re = re_of(f, i);
        smp_im = im_of(f, i);
        last_en_cyc = cyc;
        model[{wr_bank_m, 8'(i)}] = {12'h000, smp_im, smp_re};
        if (i == 255) wr_bank_m = ~wr_bank_m;
        @(posedge clk); #1;
        smp_en = 1'b0;
        @(posedge clk);
    endtask

    task automatic send_frame(input int f);
        for (int i = 0; i < 256; i++) send(f, i);
    endtask

    // Reader: fetches each handed-over bank, then releases it
    initial begin
        forever begin
            wait (rdy_q.size() > 0);
            begin
                logic b;
                int a;
                b = rdy_q.pop_front();
                reader_busy = 1'b1;
                a = 0;
                while (a < 256) begin
                    @(posedge clk); #1;
                    rd_req  = 1'b1;
                    rd_addr = 8'(a);
                    @(negedge clk);
                    if (rd_ack) begin
                        exp_q.push_back(model[{b, 8'(a)}]);
                        a++;
                    end
                end
                @(posedge clk); #1;
                rd_req  = 1'b0;
                rd_done = 1'b1;
                @(posedge clk); #1;
                rd_done = 1'b0;
                reader_busy = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Main sequence
    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(frm_rdy == 1'b0, "R1 frm_rdy", frm_rdy, 0);
        chk(rd_vld == 1'b0, "R1 rd_vld", rd_vld, 0);
        chk(rd_ack == 1'b0, "R1 rd_ack", rd_ack, 0);
        chk(overrun == 1'b0, "R1 overrun", overrun, 0);

        // Streaming frames with a concurrent reader
        reader_on = 1'b1;
        for (int f = 0; f < 4; f++) send_frame(f);
        repeat (10) @(posedge clk);
        wait (rdy_q.size() == 0 && !reader_busy);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R8 all read", exp_q.size(), 0);
        chk(overrun == 1'b0, "R7 no overrun when released", overrun, 0);

        // Overrun: the reader holds off its release
        reader_on = 1'b0;
        send_frame(4);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(overrun == 1'b0, "R7 first unreleased frame", overrun, 0);
        send_frame(5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(overrun == 1'b1, "R7 overrun set", overrun, 1);
        @(posedge clk); #1 rd_done = 1'b1;
        @(posedge clk); #1 rd_done = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(overrun == 1'b1, "R7 overrun sticky", overrun, 1);
        send_frame(6);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(frm_cnt == 7, "R3 R7 frame count", frm_cnt, 7);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule